// File: doc/BRIEF.md
# PCI Target Burst Buffer Controller

This block sits between the target side of a PCI host bridge and the local memory bus. It takes commands that have already been decoded and carry a doubleword address. It runs each transfer as one burst through one of two private FIFOs. Each FIFO holds up to `BURST_LEN` doublewords, 64 by default. Writes are posted into the write FIFO and then drained to memory. Reads are fetched from memory into the read FIFO and handed back to the PCI side in address order.

A plain memory read fetches exactly one doubleword. A read-multiple prefetches consecutive doublewords up to the last word of the aligned `BURST_LEN`-word window that holds the start address. For every burst the memory side requests the local bus once and keeps it until the memory part of the burst is done. It then releases the bus.

The PCI side can end a burst early with `pci_stop`. Prefetched words that were not consumed are then thrown away. A new command is only taken after every posted word has reached memory, so a read always observes earlier writes.

Top module: `pci_burst_buf`

## Requirements
- R1: During and after reset, `cmd_ready` is 1 and `mem_req`, `mem_hold`, `rd_valid` and `wr_ready` are 0.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both 1. The `cmd_kind` encoding is 2'b00 plain read, 2'b01 read-multiple, 2'b10 write and 2'b11 write-and-invalidate. Both write kinds behave the same.
- R3: A plain read performs exactly one memory read, at `cmd_addr`.
- R4: A read-multiple that is not stopped performs `BURST_LEN - cmd_addr[5:0]` memory reads at consecutive addresses starting at `cmd_addr`. With the default parameters this is 64 minus the low six address bits.
- R5: Fetched words appear on `rd_data` in address order. A word is consumed on each cycle where `rd_valid` and `rd_ready` are both 1, and `rd_ready` may be withheld at any time.
- R6: `pci_stop` during a read ends the burst. Prefetching stops, `rd_valid` is 0 from the next cycle on, and no unconsumed word is delivered to any later command.
- R7: During a write, words are accepted while `wr_valid` and `wr_ready` are both 1. Posting ends on `pci_stop` or after the `BURST_LEN`-th accepted word, and `wr_ready` is 0 from then on. A write stopped with no words performs no memory access.
- R8: Posted words are written with `mem_we` in acceptance order, to consecutive addresses starting at `cmd_addr`, each exactly once.
- R9: Memory is accessed only while `mem_hold` is 1. `mem_req` rises while the bus is needed and not yet held, and `mem_hold` follows a grant. `mem_hold` stays 1 until the burst's memory transfers are finished, giving exactly one hold period per burst that touches memory.
- R10: `cmd_ready` stays 0 until every posted word has been written, so a read issued after a write returns the written data.
- R11: Neither FIFO is pushed when full or popped when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded command present |
| cmd_kind | input | 2 | Command encoding (see R2) |
| cmd_addr | input | ADDR_W | Start doubleword address |
| cmd_ready | output | 1 | Block idle and able to take a command |
| pci_stop | input | 1 | PCI side ends the current burst |
| wr_valid | input | 1 | Write word present |
| wr_data | input | DATA_W | Write word |
| wr_ready | output | 1 | Write FIFO accepts a word |
| rd_valid | output | 1 | Read word present |
| rd_data | output | DATA_W | Read word |
| rd_ready | input | 1 | PCI side takes the read word |
| mem_req | output | 1 | Local bus request |
| mem_gnt | input | 1 | Local bus grant |
| mem_hold | output | 1 | Local bus owned for the burst |
| mem_we | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe; data returns the same cycle |
| mem_addr | output | ADDR_W | Memory doubleword address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The embedded properties check several rules on every cycle:
- `cmd_ready` never rises while posted data is still waiting.
- Hold is never dropped while the write FIFO still has words to drain.
- Hold is only taken after a grant.
- Write acceptance stops at the burst limit.
- A stop leaves the read path empty.
- No FIFO overflows or underflows, and the read FIFO never holds more words than were fetched.

Only the bench scenarios can show that the data is right. They check the exact number of fetched words at each window offset, the write addresses and the order of words. They also check that stopped prefetches leak no stale word, that a read after a write sees the new data, and that a delayed grant holds off every access.

// File: rtl/pcibb_pkg.sv
package pcibb_pkg;

    typedef enum logic [1:0] {
        CMD_RD_SINGLE = 2'b00,
        CMD_RD_MULTI  = 2'b01,
        CMD_WR_POST   = 2'b10,
        CMD_WR_INVAL  = 2'b11
    } pci_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_POST,
        PH_DRAIN,
        PH_FETCH
    } burst_phase_e;

    function automatic logic cmd_is_write(pci_cmd_e c);
        return c[1];
    endfunction

    // number of memory reads a read command performs
    function automatic int unsigned fetch_span(int unsigned burst, int unsigned offset, logic multi);
        return multi ? (burst - offset) : 1;
    endfunction

endpackage

// File: rtl/burst_fifo.sv
module burst_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push && !flush) store[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) (push && !pop) |-> (cnt_q < CNT_W'(DEPTH))) else $error("fifo overflow"); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> (cnt_q != '0)) else $error("fifo underflow"); // R11

endmodule

// File: rtl/bus_owner.sv
module bus_owner (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic gnt,
    output logic req,
    output logic owned
);
    assign req = want && !owned;

    always_ff @(posedge clk) begin
        if (rst)           owned <= 1'b0;
        else if (!want)    owned <= 1'b0;
        else if (req && gnt) owned <= 1'b1;
    end

    AST_HOLD_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst) (owned && !$past(owned)) |-> $past(req && gnt)) else $error("hold without grant"); // R9

endmodule

// File: rtl/pci_burst_buf.sv
module pci_burst_buf
    import pcibb_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 16,
    parameter int BURST_LEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    input  logic              pci_stop,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_ready,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_hold,
    output logic              mem_we,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(BURST_LEN);
    localparam int CNT_W = OFF_W + 1;

    burst_phase_e      phase_q, phase_d;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  xfer_q, target_q, post_q;
    pci_cmd_e          cmd_e;
    logic              accept, bus_want, owned;

    logic              wf_push, wf_pop, wf_empty, wf_full;
    logic [DATA_W-1:0] wf_dout;
    logic [CNT_W-1:0]  wf_count;
    logic              rf_push, rf_pop, rf_empty, rf_full, rf_flush;
    logic [DATA_W-1:0] rf_dout;
    logic [CNT_W-1:0]  rf_count;

    assign cmd_e     = pci_cmd_e'(cmd_kind);
    assign cmd_ready = (phase_q == PH_IDLE) && !owned;
    assign accept    = cmd_valid && cmd_ready;
    assign mem_hold  = owned;

    // write side: post, then drain under the held bus
    assign wr_ready  = (phase_q == PH_POST) && (post_q < CNT_W'(BURST_LEN));
    assign wf_push   = wr_valid && wr_ready;
    assign mem_we    = (phase_q == PH_DRAIN) && owned && !wf_empty;
    assign wf_pop    = mem_we;
    assign mem_wdata = wf_dout;

    // read side: prefetch while serving
    assign mem_rd    = (phase_q == PH_FETCH) && owned && (xfer_q < target_q);
    assign rf_push   = mem_rd;
    assign rd_valid  = (phase_q == PH_FETCH) && !rf_empty;
    assign rf_pop    = rd_valid && rd_ready;
    assign rf_flush  = (phase_q == PH_FETCH) && pci_stop;
    assign rd_data   = rf_dout;

    assign mem_addr  = base_q + ADDR_W'(xfer_q);

    always_comb begin
        case (phase_q)
            PH_DRAIN: bus_want = !wf_empty;
            PH_FETCH: bus_want = (xfer_q < target_q) && !pci_stop;
            default:  bus_want = 1'b0;
        endcase
    end

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (accept) phase_d = cmd_is_write(cmd_e) ? PH_POST : PH_FETCH;
            PH_POST:  if (pci_stop || (wf_push && post_q == CNT_W'(BURST_LEN - 1))) phase_d = PH_DRAIN;
            PH_DRAIN: if (wf_empty) phase_d = PH_IDLE;
            PH_FETCH: begin
                if (pci_stop) phase_d = PH_IDLE;
                else if (xfer_q == target_q && rf_empty) phase_d = PH_IDLE;
            end
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            base_q   <= '0;
            xfer_q   <= '0;
            target_q <= '0;
            post_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                base_q   <= cmd_addr;
                xfer_q   <= '0;
                post_q   <= '0;
                target_q <= CNT_W'(fetch_span(BURST_LEN, int'(cmd_addr[OFF_W-1:0]),
                                              cmd_e == CMD_RD_MULTI));
            end else begin
                if (mem_we || mem_rd) xfer_q <= xfer_q + 1'b1;
                if (wf_push)          post_q <= post_q + 1'b1;
            end
        end
    end

    burst_fifo #(.W(DATA_W), .DEPTH(BURST_LEN)) u_wr_fifo (
        .clk(clk), .rst(rst), .flush(1'b0),
        .push(wf_push), .din(wr_data), .pop(wf_pop), .dout(wf_dout),
        .count(wf_count), .empty(wf_empty), .full(wf_full)
    );

    burst_fifo #(.W(DATA_W), .DEPTH(BURST_LEN)) u_rd_fifo (
        .clk(clk), .rst(rst), .flush(rf_flush),
        .push(rf_push), .din(mem_rdata), .pop(rf_pop), .dout(rf_dout),
        .count(rf_count), .empty(rf_empty), .full(rf_full)
    );

    bus_owner u_owner (
        .clk(clk), .rst(rst), .want(bus_want), .gnt(mem_gnt),
        .req(mem_req), .owned(owned)
    );

    AST_HOLD_UNTIL_DRAINED: assert property (@(posedge clk) disable iff (rst) (phase_q == PH_DRAIN && mem_hold && !wf_empty) |=> mem_hold) else $error("hold dropped early"); // R9
    AST_READY_MEANS_DRAINED: assert property (@(posedge clk) disable iff (rst) cmd_ready |-> wf_empty) else $error("ready with posted data"); // R10
    AST_POST_LIMIT: assert property (@(posedge clk) disable iff (rst) wr_ready |-> (!wf_full && wf_count < CNT_W'(BURST_LEN))) else $error("post past limit"); // R7
    AST_FETCH_BOUND: assert property (@(posedge clk) disable iff (rst) (phase_q == PH_FETCH) |-> (xfer_q <= target_q && rf_count <= xfer_q)) else $error("fetch overrun"); // R4
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst) (phase_q == PH_FETCH && pci_stop) |=> (!rd_valid && rf_empty)) else $error("stale read data"); // R6
    AST_RD_ROOM: assert property (@(posedge clk) disable iff (rst) mem_rd |-> !rf_full) else $error("read fifo full"); // R11

endmodule

// File: tb/pci_burst_buf_tb.sv
module pci_burst_buf_tb;
    localparam int DW = 32;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_ready;
    logic          pci_stop = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_ready = 1'b0;
    logic          mem_req, mem_gnt, mem_hold, mem_we, mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          gnt_en = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] bmem    [256];
    logic [DW-1:0] exp_mem [256];
    int            wq_addr [$];
    logic [DW-1:0] wq_data [$];
    int            rd_base = 0, rd_taken = 0, rd_strobes = 0, we_cnt = 0, hold_periods = 0;
    logic          hold_prev = 1'b0;
    string         cur_tag = "R5";

    always #4 clk = ~clk;

    pci_burst_buf #(.DATA_W(DW), .ADDR_W(AW), .BURST_LEN(64)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .cmd_ready(cmd_ready), .pci_stop(pci_stop), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_hold(mem_hold), .mem_we(mem_we),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] seed(int a);
        return 32'h5A00_0000 ^ (a * 32'h0001_0203);
    endfunction

    // memory and arbiter models
    assign mem_gnt   = mem_req && gnt_en;
    assign mem_rdata = bmem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bmem[i] <= seed(i);
        end else if (mem_we) begin
            bmem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the behavioural model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if ((mem_we || mem_rd) && !mem_hold) chk(1'b0, "R9 access without hold", 1, 0);
            if (mem_req && mem_hold) chk(1'b0, "R9 request while held", 1, 0);
            if (cmd_ready && wq_addr.size() != 0) chk(1'b0, "R10 ready before drain", wq_addr.size(), 0);
            if (mem_we) begin
                if (wq_addr.size() == 0) chk(1'b0, "R8 unexpected write", mem_addr, 0);
                else begin
                    chk(mem_addr == AW'(wq_addr[0]), "R8 write address", mem_addr, wq_addr[0]);
                    chk(mem_wdata == wq_data[0], "R8 write data", mem_wdata, wq_data[0]);
                    void'(wq_addr.pop_front());
                    void'(wq_data.pop_front());
                    we_cnt++;
                end
            end
            if (mem_rd) begin
                chk(mem_addr == AW'(rd_base + rd_strobes), "R4 fetch address", mem_addr, rd_base + rd_strobes);
                rd_strobes++;
            end
            if (rd_valid && rd_ready) begin
                chk(rd_data == exp_mem[(rd_base + rd_taken) & 255], cur_tag, rd_data,
                    exp_mem[(rd_base + rd_taken) & 255]);
                rd_taken++;
            end
            if (hold_prev && !mem_hold) hold_periods++;
        end
        hold_prev = mem_hold;
    end

    task automatic issue_cmd(input logic [1:0] kind, input int addr);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_kind  = kind;
        cmd_addr  = AW'(addr);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] kind, input int addr, input int n, input string tag);
        int hp0 = hold_periods;
        we_cnt = 0;
        issue_cmd(kind, addr);
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] v = 32'hD000_0000 + DW'(addr << 8) + DW'(i);
            wr_valid = 1'b1;
            wr_data  = v;
            while (!wr_ready) @(negedge clk);
            wq_addr.push_back(addr + i);
            wq_data.push_back(v);
            exp_mem[(addr + i) & 255] = v;
            @(negedge clk);
        end
        if (n < 64) begin
            wr_valid = 1'b0;
            pci_stop = 1'b1;
            @(negedge clk);
            pci_stop = 1'b0;
        end else begin
            wr_valid = 1'b1;
            wr_data  = 32'hBAD0_BAD0;
            chk(wr_ready == 1'b0, "R7 word beyond limit refused", wr_ready, 0);
            @(negedge clk);
            wr_valid = 1'b0;
        end
        while (!cmd_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        #2;
        chk(wq_addr.size() == 0, {tag, " all posted words written"}, wq_addr.size(), 0);
        chk(we_cnt == n, {tag, " write count"}, we_cnt, n);
        chk(hold_periods - hp0 == ((n > 0) ? 1 : 0), "R9 hold periods per write", hold_periods - hp0, (n > 0) ? 1 : 0);
    endtask

    task automatic do_read(input logic [1:0] kind, input int addr, input int stop_after,
                           input bit throttle, input int gnt_delay, input string tag);
        int hp0    = hold_periods;
        int target = (kind == 2'b01) ? (64 - (addr % 64)) : 1;
        int c      = 0;
        rd_base    = addr;
        rd_taken   = 0;
        rd_strobes = 0;
        cur_tag    = tag;
        rd_ready   = (stop_after == 0);
        if (gnt_delay > 0) gnt_en = 1'b0;
        issue_cmd(kind, addr);
        if (gnt_delay > 0) begin
            repeat (gnt_delay) @(negedge clk);
            #2;
            chk(mem_req && !mem_hold && rd_strobes == 0, "R9 no access before grant",
                {mem_req, mem_hold}, 2'b10);
            gnt_en = 1'b1;
            @(negedge clk);
        end
        if (stop_after > 0) begin
            repeat (stop_after) @(negedge clk);
            pci_stop = 1'b1;
            @(negedge clk);
            pci_stop = 1'b0;
            #2;
            chk(!rd_valid, "R6 no read data after stop", rd_valid, 0);
            while (!cmd_ready) @(negedge clk);
            repeat (2) @(negedge clk);
            #2;
            chk(rd_strobes > 0 && rd_strobes < target, "R6 prefetch cut short", rd_strobes, target);
            chk(rd_taken == 0, "R6 no word delivered", rd_taken, 0);
        end else begin
            while (!cmd_ready) begin
                rd_ready = throttle ? ((c % 3) != 2) : 1'b1;
                c++;
                @(negedge clk);
            end
            rd_ready = 1'b0;
            repeat (2) @(negedge clk);
            #2;
            chk(rd_strobes == target, (kind == 2'b00) ? "R3 single fetch count" : "R4 prefetch count",
                rd_strobes, target);
            chk(rd_taken == target, {tag, " words delivered"}, rd_taken, target);
            chk(hold_periods - hp0 == 1, "R9 one hold period per read", hold_periods - hp0, 1);
        end
        rd_ready = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = seed(i);
        repeat (3) @(negedge clk);
        chk(cmd_ready && !mem_req && !mem_hold && !rd_valid && !wr_ready, "R1 state in reset",
            {cmd_ready, mem_req, mem_hold, rd_valid, wr_ready}, 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !mem_req && !mem_hold && !rd_valid && !wr_ready, "R1 state after reset",
            {cmd_ready, mem_req, mem_hold, rd_valid, wr_ready}, 5'b10000);

        // R2 R7 R8: short posted write, then R10 read-after-write
        do_write(2'b10, 16, 4, "R8");
        do_read(2'b00, 18, 0, 1'b0, 0, "R10");
        // R4 R5: prefetch from mid-window, throttled consumer
        do_read(2'b01, 133, 0, 1'b1, 0, "R5");
        // R4: aligned start, full window
        do_read(2'b01, 64, 0, 1'b0, 0, "R5");
        // R4: last word of a window
        do_read(2'b01, 127, 0, 1'b0, 0, "R4");
        // R7 R8: full-length write-and-invalidate, then R10 read it back
        do_write(2'b11, 160, 64, "R7");
        do_read(2'b01, 160, 0, 1'b1, 0, "R10");
        // R6: stopped prefetch, then a fresh plain read must be clean
        do_read(2'b01, 0, 8, 1'b0, 0, "R6");
        do_read(2'b00, 192, 0, 1'b0, 0, "R6");
        // R7: write stopped with zero words
        do_write(2'b10, 40, 0, "R7");
        // R9: delayed grant on a plain read
        do_read(2'b00, 77, 0, 1'b0, 5, "R3");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule